// File: doc/BRIEF.md
# Debug Signal Routing Switch

This block sits in the I/O section of a microcontroller, between the normal port logic and six pad cells. An 8-bit control register selects one of sixteen groups of internal signals. When the register's enable field is set, that group drives the six pins in place of their normal port data. A pin's output driver still turns on only if that pin's direction bit is already set.

The same register holds a CPU-busy flag. Hardware sets this flag when an interrupt is entered, and software can set or clear it by writing the register. A two-bit field can route the flag onto one of three of the six pins. On the chosen pin the flag forces the driver on, whatever the direction bit says.

The internal signal sources reach the block as one flat vector of 96 bits. The block does not generate them.

Top module: `dbg_route_switch`

## Requirements
- R1: After reset the control register reads 0x00. `reg_rd_data` always shows the current register value, including a busy flag set by hardware. Without a write or an interrupt pulse the value holds.
- R2: A write with `reg_wr_en` high stores all 8 bits of `reg_wr_data`. The new value is visible from the cycle after the write edge.
- R3: The field layout is: bit 7 enables group routing, bit 6 is the busy flag, bits 5:4 select the busy pin, and bits 3:0 select the group.
- R4: While routing is enabled, pin p (p = 0..5) drives bit g*6+p of `dbg_src`, where g is the group code. Its `pin_oe` equals `port_dir[p]`.
- R5: Some lanes drive 0 whatever the source bits are. Pins 4 and 5 are 0 for groups 1, 2, 6 and 7. Pin 0 is 0 for groups 3 and 13.
- R6: An `irq_entry` pulse sets the busy flag at the next edge. If a write that clears the flag happens in the same cycle, the pulse still wins.
- R7: A software write sets the busy flag when bit 6 of the written value is 1 and clears it when bit 6 is 0.
- R8: The busy pin select is encoded as 00 = none, 01 = pin 4, 10 = pin 5, 11 = pin 0. The selected pin drives the busy flag with `pin_oe` = 1, whatever its direction bit is.
- R9: When the busy pin select and group routing claim the same pin, the busy flag drives that pin.
- R10: A pin that is not claimed by the busy output, on a register whose enable bit is 0, passes `port_dout` and `port_dir` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Current register value |
| irq_entry | input | 1 | One-cycle pulse when an interrupt is entered |
| dbg_src | input | 96 | Internal debug signals, 16 groups of 6 lanes, lane p of group g at bit g*6+p |
| port_dout | input | 6 | Normal port output data for the six pins |
| port_dir | input | 6 | Normal port direction bits, 1 = output |
| pin_dout | output | 6 | Data to the pads |
| pin_oe | output | 6 | Output driver enables to the pads |

## Verification
If the register or the busy flag holds a wrong value, it shows on `reg_rd_data` in the cycle after the edge that caused it. Because the pin outputs depend on the register only through combinational logic, the same error reaches `pin_dout` or `pin_oe` in that same cycle. An error in group selection, in a zeroed lane or in the precedence between the busy output and the group appears at the pins as soon as the inputs settle. The bench runs such cases with source patterns that are all ones and with patterns that vary from lane to lane, so a wrong lane or a missing zero changes a visible bit.

// File: rtl/dbg_route_pkg.sv
// Package dbg_route_pkg
// Shared sizes, control register layout and lane constants for the debug
// routing switch. Assumes six routed pins and sixteen signal groups.
package dbg_route_pkg;

    localparam int PIN_COUNT   = 6;
    localparam int GROUP_COUNT = 16;
    localparam int GRP_SEL_W   = $clog2(GROUP_COUNT);
    localparam int SRC_W       = GROUP_COUNT * PIN_COUNT;

    // Pins that the busy flag can be steered to
    localparam int BUSY_PIN_SEL1 = 4;
    localparam int BUSY_PIN_SEL2 = 5;
    localparam int BUSY_PIN_SEL3 = 0;

    // Control register fields, MSB first
    typedef struct packed {
        logic                 route_en;
        logic                 busy;
        logic [1:0]           busy_pin;
        logic [GRP_SEL_W-1:0] grp;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Lanes that carry a fixed zero
    function automatic logic lane_is_zero(input int g, input int l);
        logic hi_pair;
        logic lo_lane;
        hi_pair = (g == 1 || g == 2 || g == 6 || g == 7) && (l >= 4);
        lo_lane = (g == 3 || g == 13) && (l == 0);
        return hi_pair || lo_lane;
    endfunction

    // Mask of the source bits that are really routed
    function automatic logic [SRC_W-1:0] src_keep_mask();
        logic [SRC_W-1:0] m;
        for (int g = 0; g < GROUP_COUNT; g++) begin
            for (int l = 0; l < PIN_COUNT; l++) begin
                m[g*PIN_COUNT+l] = !lane_is_zero(g, l);
            end
        end
        return m;
    endfunction

    // One-hot pin claim for a busy select code
    function automatic logic [PIN_COUNT-1:0] busy_claim(input logic [1:0] sel);
        logic [PIN_COUNT-1:0] oh;
        oh = '0;
        case (sel)
            2'b01:   oh[BUSY_PIN_SEL1] = 1'b1;
            2'b10:   oh[BUSY_PIN_SEL2] = 1'b1;
            2'b11:   oh[BUSY_PIN_SEL3] = 1'b1;
            default: oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/dbg_ctrl_reg.sv
// Module dbg_ctrl_reg
// Holds the control register. A software write loads all bits. An interrupt
// entry pulse forces the busy bit to 1 and beats a write in the same cycle.
// Assumes irq_entry lasts one cycle per interrupt and is synchronous to clk.
module dbg_ctrl_reg
    import dbg_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              irq_entry,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;

    // Next value: a write loads all fields, then the hardware busy set applies
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = ctrl_t'(wr_data);
        end
        if (irq_entry) begin
            ctrl_d.busy = 1'b1;
        end
    end

    // Register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/dbg_group_mux.sv
// Module dbg_group_mux
// Chooses one group of lanes from the flat source vector. Lanes fixed at
// zero are masked off. Assumes lane l of group g sits at bit g*LANES+l.
module dbg_group_mux
    import dbg_route_pkg::*;
#(
    parameter int LANES  = PIN_COUNT,
    parameter int GROUPS = GROUP_COUNT
) (
    input  logic [GROUPS*LANES-1:0]   src,
    input  logic [$clog2(GROUPS)-1:0] sel,
    output logic [LANES-1:0]          lanes
);

    localparam int TOTAL = GROUPS * LANES;
    localparam logic [TOTAL-1:0] KEEP = TOTAL'(src_keep_mask());

    logic [TOTAL-1:0] src_kept;

    // Clear the lanes that must read zero
    assign src_kept = src & KEEP;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [GROUPS-1:0] column;
            genvar g;
            for (g = 0; g < GROUPS; g++) begin : g_col
                assign column[g] = src_kept[g*LANES+l];
            end
            // Select the chosen group for this lane
            assign lanes[l] = column[sel];
        end
    endgenerate

endmodule

// File: rtl/dbg_pin_override.sv
// Module dbg_pin_override
// Decides what each pin drives. The busy output comes first and forces the
// driver on. Group routing comes next and keeps the port's direction bit.
// Otherwise the normal port signals pass through unchanged.
module dbg_pin_override #(
    parameter int PINS = 6
) (
    input  logic [PINS-1:0] busy_claim,
    input  logic            busy_val,
    input  logic            route_en,
    input  logic [PINS-1:0] grp_lanes,
    input  logic [PINS-1:0] port_dout,
    input  logic [PINS-1:0] port_dir,
    output logic [PINS-1:0] pin_dout,
    output logic [PINS-1:0] pin_oe
);

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            // Priority between the busy output, the group and the port
            always_comb begin
                if (busy_claim[p]) begin
                    pin_dout[p] = busy_val;
                    pin_oe[p]   = 1'b1;
                end else if (route_en) begin
                    pin_dout[p] = grp_lanes[p];
                    pin_oe[p]   = port_dir[p];
                end else begin
                    pin_dout[p] = port_dout[p];
                    pin_oe[p]   = port_dir[p];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dbg_route_switch.sv
// Module dbg_route_switch
// Top level of the debug routing switch. Contains the control register, the
// group multiplexer and the per-pin override. Register reads return the
// live register value. The pins follow the register with no extra delay.
module dbg_route_switch
    import dbg_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [CTRL_W-1:0]    reg_wr_data,
    output logic [CTRL_W-1:0]    reg_rd_data,
    input  logic                 irq_entry,
    input  logic [SRC_W-1:0]     dbg_src,
    input  logic [PIN_COUNT-1:0] port_dout,
    input  logic [PIN_COUNT-1:0] port_dir,
    output logic [PIN_COUNT-1:0] pin_dout,
    output logic [PIN_COUNT-1:0] pin_oe
);

    ctrl_t                ctrl;
    logic [PIN_COUNT-1:0] grp_lanes;
    logic [PIN_COUNT-1:0] claim;

    dbg_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .irq_entry (irq_entry),
        .ctrl      (ctrl)
    );

    dbg_group_mux #(
        .LANES  (PIN_COUNT),
        .GROUPS (GROUP_COUNT)
    ) u_mux (
        .src   (dbg_src),
        .sel   (ctrl.grp),
        .lanes (grp_lanes)
    );

    // Decode the busy pin select into a per-pin claim
    assign claim = busy_claim(ctrl.busy_pin);

    dbg_pin_override #(
        .PINS (PIN_COUNT)
    ) u_pins (
        .busy_claim (claim),
        .busy_val   (ctrl.busy),
        .route_en   (ctrl.route_en),
        .grp_lanes  (grp_lanes),
        .port_dout  (port_dout),
        .port_dir   (port_dir),
        .pin_dout   (pin_dout),
        .pin_oe     (pin_oe)
    );

    // Present the live register value for reads
    assign reg_rd_data = ctrl;

endmodule

// File: rtl/dbg_route_switch_chk.sv
// Module dbg_route_switch_chk
// Property checker for dbg_route_switch, attached with bind. It only
// observes the top-level ports.
module dbg_route_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [7:0] reg_wr_data,
    input logic [7:0] reg_rd_data,
    input logic       irq_entry,
    input logic [5:0] port_dout,
    input logic [5:0] port_dir,
    input logic [5:0] pin_dout,
    input logic [5:0] pin_oe
);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !irq_entry) |=> $stable(reg_rd_data));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !irq_entry) |=> (reg_rd_data == $past(reg_wr_data)));

    a_r6_irq_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq_entry |=> reg_rd_data[6]);

    a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_data[6] && !irq_entry) |=> !reg_rd_data[6]);

    a_r8_busy_pin4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[5:4] == 2'b01) |-> (pin_oe[4] && pin_dout[4] == reg_rd_data[6]));

    a_r8_busy_pin0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[5:4] == 2'b11) |-> (pin_oe[0] && pin_dout[0] == reg_rd_data[6]));

    a_r4_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[7] && reg_rd_data[5:4] == 2'b00) |-> (pin_oe == port_dir));

    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_data[7] && reg_rd_data[5:4] == 2'b00) |->
        (pin_dout == port_dout && pin_oe == port_dir));

endmodule

bind dbg_route_switch dbg_route_switch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .irq_entry   (irq_entry),
    .port_dout   (port_dout),
    .port_dir    (port_dir),
    .pin_dout    (pin_dout),
    .pin_oe      (pin_oe)
);

// File: tb/dbg_route_switch_tb.sv
module dbg_route_switch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic [7:0]  reg_rd_data;
    logic        irq_entry = 1'b0;
    logic [95:0] dbg_src = '0;
    logic [5:0]  port_dout = '0;
    logic [5:0]  port_dir = '0;
    logic [5:0]  pin_dout;
    logic [5:0]  pin_oe;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_route_switch u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .irq_entry   (irq_entry),
        .dbg_src     (dbg_src),
        .port_dout   (port_dout),
        .port_dir    (port_dir),
        .pin_dout    (pin_dout),
        .pin_oe      (pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of the R5 zero lanes, built from the requirement text
    function automatic logic [5:0] exp_group(input int g, input logic [95:0] src);
        logic [5:0] v;
        for (int l = 0; l < 6; l++) begin
            v[l] = src[g*6+l];
            if ((g == 1 || g == 2 || g == 6 || g == 7) && l >= 4) v[l] = 1'b0;
            if ((g == 3 || g == 13) && l == 0) v[l] = 1'b0;
        end
        return v;
    endfunction

    // One write cycle, then sample after the next falling edge
    task automatic wr_reg(input logic [7:0] d, input logic irq);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        irq_entry   = irq;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        irq_entry   = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        port_dout = 6'b101101;
        port_dir  = 6'b110010;
        #1;
        chk("R1 reset value", reg_rd_data, 8'h00);
        chk("R10 reset pass dout", pin_dout, 6'b101101);
        chk("R10 reset pass oe", pin_oe, 6'b110010);
    endtask

    task automatic t_write_read;
        wr_reg(8'h5A, 1'b0);
        chk("R2 write 5A", reg_rd_data, 8'h5A);
        @(negedge clk); #1;
        chk("R1 hold idle", reg_rd_data, 8'h5A);
        wr_reg(8'hA5, 1'b0);
        chk("R2 write A5", reg_rd_data, 8'hA5);
    endtask

    task automatic t_groups(input logic [95:0] pattern);
        dbg_src   = pattern;
        port_dir  = 6'b111111;
        port_dout = 6'b000000;
        for (int g = 0; g < 16; g++) begin
            wr_reg(8'h80 | 8'(g), 1'b0);
            chk("R4 group route", pin_dout, exp_group(g, pattern));
            chk("R3 group oe dir", pin_oe, 6'b111111);
        end
    endtask

    task automatic t_zero_lanes;
        dbg_src = '1;
        wr_reg(8'h81, 1'b0);
        chk("R5 group1 top lanes", pin_dout, 6'b001111);
        wr_reg(8'h87, 1'b0);
        chk("R5 group7 top lanes", pin_dout, 6'b001111);
        wr_reg(8'h83, 1'b0);
        chk("R5 group3 lane0", pin_dout, 6'b111110);
        wr_reg(8'h8D, 1'b0);
        chk("R5 group13 lane0", pin_dout, 6'b111110);
    endtask

    task automatic t_oe_gate;
        dbg_src  = '1;
        port_dir = 6'b010101;
        wr_reg(8'h80, 1'b0);
        #1;
        chk("R4 oe gated by dir", pin_oe, 6'b010101);
        chk("R4 data still routed", pin_dout, 6'b111111);
    endtask

    task automatic t_busy_out;
        port_dir  = 6'b000000;
        port_dout = 6'b000000;
        wr_reg(8'h50, 1'b0);
        chk("R8 sel01 oe", pin_oe, 6'b010000);
        chk("R8 sel01 dout", pin_dout, 6'b010000);
        wr_reg(8'h60, 1'b0);
        chk("R8 sel10 oe", pin_oe, 6'b100000);
        chk("R8 sel10 dout", pin_dout, 6'b100000);
        wr_reg(8'h70, 1'b0);
        chk("R8 sel11 oe", pin_oe, 6'b000001);
        chk("R8 sel11 dout", pin_dout, 6'b000001);
        wr_reg(8'h30, 1'b0);
        chk("R8 busy low drives 0", pin_dout, 6'b000000);
        chk("R8 busy low oe", pin_oe, 6'b000001);
    endtask

    task automatic t_conflict;
        dbg_src  = '1;
        port_dir = 6'b111111;
        wr_reg(8'h90, 1'b0);
        chk("R9 busy beats group", pin_dout, 6'b101111);
        chk("R9 oe", pin_oe, 6'b111111);
        port_dir = 6'b000000;
        #1;
        chk("R9 busy oe no dir", pin_oe, 6'b010000);
    endtask

    task automatic t_busy_flag;
        wr_reg(8'h00, 1'b0);
        chk("R7 clear", reg_rd_data, 8'h00);
        @(negedge clk);
        irq_entry = 1'b1;
        @(negedge clk);
        irq_entry = 1'b0;
        #1;
        chk("R6 irq sets busy", reg_rd_data, 8'h40);
        wr_reg(8'h00, 1'b0);
        chk("R7 soft clear", reg_rd_data, 8'h00);
        wr_reg(8'h40, 1'b0);
        chk("R7 soft set", reg_rd_data, 8'h40);
        wr_reg(8'h03, 1'b1);
        chk("R6 irq beats write 0", reg_rd_data, 8'h43);
    endtask

    task automatic t_disabled;
        port_dout = 6'b110011;
        port_dir  = 6'b011110;
        dbg_src   = '1;
        wr_reg(8'h0F, 1'b0);
        chk("R10 disabled dout", pin_dout, 6'b110011);
        chk("R10 disabled oe", pin_oe, 6'b011110);
        wr_reg(8'h6F, 1'b0);
        chk("R10 other pins pass", pin_dout, 6'b110011);
        chk("R10 busy pin oe", pin_oe, 6'b111110);
    endtask

    initial begin : wd
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) disable wd;
        end
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_write_read();
        t_groups({16{6'b101101}} ^ {6{16'hC35A}});
        t_groups({48{2'b10}});
        t_zero_lanes();
        t_oe_gate();
        t_busy_out();
        t_conflict();
        t_busy_flag();
        t_disabled();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule